// File: doc/BRIEF.md
# Block-Splitting DMA Transfer Sequencer

This block takes one DMA transfer command at a time and carries it out as a chain of memory transactions, none of which crosses a memory-block boundary. A command gives a start address, a byte count and a direction. The sequencer cuts the first transaction at the end of the block that holds the start address. Every later transaction starts block-aligned. It covers a whole block, or whatever bytes remain.

Only one transaction is in flight at a time. A store piece waits for an acknowledge. A load piece waits for a returned data block, and the wanted bytes of that block are packed into a local byte buffer. Before a store, the host fills the same buffer. After a load, the host reads the result back from it.

When every byte is complete, the sequencer pulses a done strobe that carries the transfer's tag and returns to idle.

Top module: `dma_block_seq`

## Requirements
- R1: `cmd_ready` is high only while the sequencer is idle. An accepted legal command raises `busy` in the next cycle, and `busy` stays high until the transfer completes.
- R2: `cmd_op` 2'b01 means load and 2'b10 means store. The codes 2'b00 and 2'b11, and any `cmd_len` above BUF_BYTES, are refused. In that case `cmd_illegal` is high in the cycle of the handshake, no transfer starts and no tag is used up.
- R3: The first piece has address = start address and offset = start address modulo BLK_BYTES. Its length is the smaller of `cmd_len` and BLK_BYTES minus that offset.
- R4: Every later piece has address = start address + bytes completed, which is block-aligned. Its offset is 0 and its length is the smaller of the remaining bytes and BLK_BYTES.
- R5: `mreq_valid` is a one-cycle pulse. No piece is issued while another is outstanding. The next piece appears in the cycle right after the completing response is sampled.
- R6: `mreq_write` is 1 for store transfers. A store piece completes only on `rsp_ack`, and a load piece completes only on `rsp_data_valid`. A response of the other kind is ignored.
- R7: For a store piece, byte k of `mreq_data` (bits 8k+7:8k) equals buffer byte (bytes completed + k) for k below the piece length. All other bytes are zero, and `mreq_data` is all zero for loads.
- R8: For a load piece, the returned block's bytes starting at the piece offset (the start offset for the first piece, 0 later), piece-length of them, are written to the buffer from position bytes completed. As a result, buffer byte k holds memory byte start + k.
- R9: In the cycle after the last response, `done_valid` pulses for one cycle with the transfer's tag on `done_id`. The sequencer is idle in the cycle after that.
- R10: A zero-length command issues no piece. `done_valid` pulses in the cycle right after acceptance.
- R11: Tags start at 0 after reset, rise by one for each accepted legal command, and wrap at 2^ID_W.
- R12: Host writes to the buffer (`buf_we`) take effect only while idle and are ignored while busy. `buf_rdata` always shows the buffer byte at `buf_ridx`.
- R13: After reset the sequencer is idle: `cmd_ready` is 1, and `busy`, `mreq_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken |
| cmd_op | input | 2 | 01 load, 10 store, others illegal |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | clog2(BUF_BYTES)+1 | Byte count |
| cmd_illegal | output | 1 | Offered command refused |
| buf_we | input | 1 | Host buffer write strobe |
| buf_widx | input | clog2(BUF_BYTES) | Host write position |
| buf_wdata | input | 8 | Host write byte |
| buf_ridx | input | clog2(BUF_BYTES) | Host read position |
| buf_rdata | output | 8 | Buffer byte at read position |
| mreq_valid | output | 1 | Piece issued this cycle |
| mreq_write | output | 1 | Piece is a store |
| mreq_addr | output | ADDR_W | Piece address |
| mreq_off | output | clog2(BLK_BYTES) | Offset inside the block |
| mreq_len | output | clog2(BUF_BYTES)+1 | Piece length in bytes |
| mreq_data | output | 8*BLK_BYTES | Store bytes, packed from byte 0 |
| rsp_ack | input | 1 | Store piece acknowledged |
| rsp_data_valid | input | 1 | Load block returned |
| rsp_data | input | 8*BLK_BYTES | Returned block, byte j at bits 8j+7:8j |
| busy | output | 1 | Transfer active |
| done_valid | output | 1 | Transfer finished |
| done_id | output | ID_W | Tag of finished transfer |

## Verification
The splitting logic is exercised with several transfer shapes:
- an unaligned load spanning three blocks, which separates first-piece arithmetic from later-piece arithmetic;
- an aligned two-block store, which shows that no short first piece is produced;
- a three-byte store that straddles a boundary, which shows that a short first cut is followed by a one-byte tail;
- a load that fits inside one block, which shows the offset is applied without splitting;
- a full-buffer load from one byte past a boundary, which reaches the length limit and the longest piece chain.

Responses of the wrong kind are injected to show they neither complete a piece nor advance the chain. A host write during a store shows the buffer is locked while busy. Refused opcodes and lengths, followed by a run of zero-length transfers, show that tags are not used up by refusals and that they wrap.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  // command opcodes seen on cmd_op
  typedef enum logic [1:0] {
    OPC_NONE  = 2'b00,
    OPC_LOAD  = 2'b01,
    OPC_STORE = 2'b10,
    OPC_RSVD  = 2'b11
  } dseq_op_e;

  // sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_ISSUE = 2'b01,
    PH_WAIT  = 2'b10
  } dseq_phase_e;

endpackage

// File: rtl/dseq_piece_calc.sv
module dseq_piece_calc #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 9,
  parameter int BLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_en,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [LEN_W-1:0]  done_cnt,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [$clog2(BLK_BYTES)-1:0] pc_off,
  output logic [LEN_W-1:0]  pc_len,
  output logic              pc_all_done
);

  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam logic [LEN_W-1:0] BLK_L = LEN_W'(BLK_BYTES);

  function automatic logic [LEN_W-1:0] len_min(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // room left in the block that holds the start byte
  function automatic logic [LEN_W-1:0] first_room(input logic [OFF_W-1:0] off);
    return BLK_L - LEN_W'(off);
  endfunction

  logic [OFF_W-1:0] start_off;
  logic [LEN_W-1:0] remain;
  logic             is_first;

  assign start_off   = start_addr[OFF_W-1:0];
  assign remain      = total_len - done_cnt;
  assign is_first    = (done_cnt == '0);
  assign pc_all_done = (done_cnt == total_len);

  assign pc_addr = start_addr + ADDR_W'(done_cnt);
  assign pc_off  = is_first ? start_off : '0;
  assign pc_len  = is_first ? len_min(total_len, first_room(start_off))
                            : len_min(remain, BLK_L);

  // R3: an issued piece is non-empty and never runs past its block end
  p_in_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> (pc_len != '0) &&
                 ((LEN_W+1)'(pc_off) + (LEN_W+1)'(pc_len) <= (LEN_W+1)'(BLK_BYTES)));

  // R4: accumulated lengths land every later piece on a block boundary
  p_later_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && !is_first) |-> (pc_addr[OFF_W-1:0] == '0));

endmodule

// File: rtl/dseq_xfer_buf.sv
module dseq_xfer_buf #(
  parameter int BUF_BYTES = 256,
  parameter int BLK_BYTES = 16,
  parameter int LEN_W     = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_we,
  input  logic [$clog2(BUF_BYTES)-1:0] host_widx,
  input  logic [7:0]                   host_wbyte,
  input  logic [$clog2(BUF_BYTES)-1:0] host_ridx,
  output logic [7:0]                   host_rbyte,
  input  logic                         fill_en,
  input  logic [BLK_BYTES*8-1:0]       fill_blk,
  input  logic [LEN_W-1:0]             fill_base,
  input  logic [LEN_W-1:0]             fill_end,
  input  logic [$clog2(BLK_BYTES)-1:0] fill_xoff,
  input  logic [LEN_W-1:0]             rd_base,
  input  logic [LEN_W-1:0]             rd_len,
  output logic [BLK_BYTES*8-1:0]       pack_blk
);

  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int OFF_W = $clog2(BLK_BYTES);

  logic [7:0] mem [BUF_BYTES];

  function automatic logic [7:0] blk_byte(input logic [BLK_BYTES*8-1:0] blk,
                                          input logic [OFF_W-1:0] k);
    return blk[int'(k)*8 +: 8];
  endfunction

  // position inside the returned block that feeds buffer entry i
  function automatic logic [OFF_W-1:0] src_pos(input int i,
                                               input logic [LEN_W-1:0] base,
                                               input logic [OFF_W-1:0] xoff);
    return OFF_W'(i - int'(base) + int'(xoff));
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < BUF_BYTES; i++) begin
      if (fill_en && (i >= int'(fill_base)) && (i < int'(fill_end)))
        mem[i] <= blk_byte(fill_blk, src_pos(i, fill_base, fill_xoff));
      else if (host_we && (host_widx == IDX_W'(i)))
        mem[i] <= host_wbyte;
    end
  end

  assign host_rbyte = mem[host_ridx];

  // outgoing store bytes: packed from byte 0 of the block
  for (genvar k = 0; k < BLK_BYTES; k++) begin : g_pack
    assign pack_blk[k*8 +: 8] =
      ((k < int'(rd_len)) && (int'(rd_base) + k < BUF_BYTES))
        ? mem[IDX_W'(int'(rd_base) + k)] : 8'h00;
  end

  // R8: the slice taken from a returned block stays inside that block
  p_fill_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (fill_end > fill_base) &&
                ((LEN_W+1)'(fill_end - fill_base) + (LEN_W+1)'(fill_xoff)
                   <= (LEN_W+1)'(BLK_BYTES)));

endmodule

// File: rtl/dma_block_seq.sv
module dma_block_seq
  import dseq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 16,
  parameter int BUF_BYTES = 256,
  parameter int ID_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [1:0]                   cmd_op,
  input  logic [ADDR_W-1:0]            cmd_addr,
  input  logic [$clog2(BUF_BYTES):0]   cmd_len,
  output logic                         cmd_illegal,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_BYTES)-1:0] buf_widx,
  input  logic [7:0]                   buf_wdata,
  input  logic [$clog2(BUF_BYTES)-1:0] buf_ridx,
  output logic [7:0]                   buf_rdata,
  output logic                         mreq_valid,
  output logic                         mreq_write,
  output logic [ADDR_W-1:0]            mreq_addr,
  output logic [$clog2(BLK_BYTES)-1:0] mreq_off,
  output logic [$clog2(BUF_BYTES):0]   mreq_len,
  output logic [BLK_BYTES*8-1:0]       mreq_data,
  input  logic                         rsp_ack,
  input  logic                         rsp_data_valid,
  input  logic [BLK_BYTES*8-1:0]       rsp_data,
  output logic                         busy,
  output logic                         done_valid,
  output logic [ID_W-1:0]              done_id
);

  localparam int LEN_W = $clog2(BUF_BYTES) + 1;
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int BLK_W = BLK_BYTES * 8;

  dseq_phase_e      ph_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q;
  logic              store_q;
  logic [ID_W-1:0]   cur_id_q;
  logic [ID_W-1:0]   next_id_q;
  logic [LEN_W-1:0]  issued_q;
  logic [LEN_W-1:0]  compl_q;

  // named events
  logic cmd_hs, cmd_bad, cmd_take;
  logic ev_issue, ev_finish, ev_resp;

  logic [ADDR_W-1:0] pc_addr;
  logic [OFF_W-1:0]  pc_off;
  logic [LEN_W-1:0]  pc_len;
  logic              pc_all_done;
  logic [BLK_W-1:0]  pack_blk;

  function automatic logic op_legal(input logic [1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE);
  endfunction

  assign cmd_ready   = (ph_q == PH_IDLE);
  assign cmd_hs      = cmd_valid && cmd_ready;
  assign cmd_bad     = !op_legal(cmd_op) || (cmd_len > LEN_W'(BUF_BYTES));
  assign cmd_take    = cmd_hs && !cmd_bad;
  assign cmd_illegal = cmd_hs && cmd_bad;

  assign ev_issue  = (ph_q == PH_ISSUE) && !pc_all_done;
  assign ev_finish = (ph_q == PH_ISSUE) && pc_all_done;
  assign ev_resp   = (ph_q == PH_WAIT) && (store_q ? rsp_ack : rsp_data_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      start_q   <= '0;
      len_q     <= '0;
      store_q   <= 1'b0;
      cur_id_q  <= '0;
      next_id_q <= '0;
      issued_q  <= '0;
      compl_q   <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (cmd_take) begin
            start_q   <= cmd_addr;
            len_q     <= cmd_len;
            store_q   <= (cmd_op == OPC_STORE);
            cur_id_q  <= next_id_q;
            next_id_q <= next_id_q + 1'b1;
            issued_q  <= '0;
            compl_q   <= '0;
            ph_q      <= PH_ISSUE;
          end
        end
        PH_ISSUE: begin
          if (ev_finish) begin
            ph_q <= PH_IDLE;
          end else begin
            issued_q <= issued_q + pc_len;
            ph_q     <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (ev_resp) begin
            compl_q <= issued_q;
            ph_q    <= PH_ISSUE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  dseq_piece_calc #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .BLK_BYTES (BLK_BYTES)
  ) i_piece (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_en    (ev_issue),
    .start_addr  (start_q),
    .total_len   (len_q),
    .done_cnt    (compl_q),
    .pc_addr     (pc_addr),
    .pc_off      (pc_off),
    .pc_len      (pc_len),
    .pc_all_done (pc_all_done)
  );

  // while waiting, piece_calc still describes the outstanding piece,
  // so its offset is the extraction offset for the returned block
  dseq_xfer_buf #(
    .BUF_BYTES (BUF_BYTES),
    .BLK_BYTES (BLK_BYTES),
    .LEN_W     (LEN_W)
  ) i_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (buf_we && (ph_q == PH_IDLE)),
    .host_widx  (buf_widx),
    .host_wbyte (buf_wdata),
    .host_ridx  (buf_ridx),
    .host_rbyte (buf_rdata),
    .fill_en    (ev_resp && !store_q),
    .fill_blk   (rsp_data),
    .fill_base  (compl_q),
    .fill_end   (issued_q),
    .fill_xoff  (pc_off),
    .rd_base    (compl_q),
    .rd_len     (pc_len),
    .pack_blk   (pack_blk)
  );

  assign mreq_valid = ev_issue;
  assign mreq_write = store_q;
  assign mreq_addr  = pc_addr;
  assign mreq_off   = pc_off;
  assign mreq_len   = pc_len;
  assign mreq_data  = store_q ? pack_blk : '0;

  assign busy       = (ph_q != PH_IDLE);
  assign done_valid = ev_finish;
  assign done_id    = cur_id_q;

  // R1: an accepted legal command makes the sequencer busy
  p_take_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> busy);

  // R2: a refused command leaves the sequencer idle
  p_refuse_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |=> !busy && cmd_ready);

  // R5: a piece is never followed directly by another piece
  p_single_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |=> !mreq_valid);

  // R5: issuing a piece advances the issued count by its length
  p_issue_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |=> (issued_q == $past(issued_q) + $past(mreq_len)));

  // R9: completion is bounded and followed by idle
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (compl_q <= issued_q) && (issued_q <= len_q));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !busy && !done_valid);

endmodule

// File: tb/test_dma_block_seq.sv
`timescale 1ns/1ps
module test_dma_block_seq;

  localparam int BLK   = 16;
  localparam int BUFB  = 256;
  localparam int BLK_W = BLK * 8;

  typedef struct {
    logic [31:0]      addr;
    int               off;
    int               len;
    bit               wr;
    bit               first;
    logic [BLK_W-1:0] data;
  } piece_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [31:0] cmd_addr = '0;
  logic [8:0] cmd_len = '0;
  logic cmd_illegal;
  logic buf_we = 1'b0;
  logic [7:0] buf_widx = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_ridx = '0;
  logic [7:0] buf_rdata;
  logic mreq_valid, mreq_write;
  logic [31:0] mreq_addr;
  logic [3:0] mreq_off;
  logic [8:0] mreq_len;
  logic [BLK_W-1:0] mreq_data;
  logic rsp_ack = 1'b0;
  logic rsp_data_valid = 1'b0;
  logic [BLK_W-1:0] rsp_data = '0;
  logic busy, done_valid;
  logic [3:0] done_id;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic [3:0] exp_id = '0;
  piece_t exp_q[$];

  // monitor state
  bit pending = 0;
  bit inject = 0;
  bit wrong_chk = 0;
  bit last_rsp = 0;
  int delay = 0;
  int npieces = 0;
  logic [31:0] cur_addr = '0;
  bit cur_wr = 0;

  always #10 clk = ~clk;   // 50 MHz

  dma_block_seq i_dma_block_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_illegal(cmd_illegal),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
    .buf_ridx(buf_ridx), .buf_rdata(buf_rdata),
    .mreq_valid(mreq_valid), .mreq_write(mreq_write), .mreq_addr(mreq_addr),
    .mreq_off(mreq_off), .mreq_len(mreq_len), .mreq_data(mreq_data),
    .rsp_ack(rsp_ack), .rsp_data_valid(rsp_data_valid), .rsp_data(rsp_data),
    .busy(busy), .done_valid(done_valid), .done_id(done_id)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd7 + 32'd3;
    return t[7:0];
  endfunction

  function automatic logic [7:0] host_byte(input int k, input int seed);
    int t;
    t = k * 5 + seed;
    return t[7:0];
  endfunction

  function automatic logic [BLK_W-1:0] mem_blk(input logic [31:0] a);
    logic [BLK_W-1:0] b;
    logic [31:0] base;
    base = a & ~32'(BLK - 1);
    for (int j = 0; j < BLK; j++) b[j*8 +: 8] = mem_byte(base + 32'(j));
    return b;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // monitor and responder: scoreboard side
  always @(negedge clk) begin
    bit prev_rsp;
    piece_t p;
    string tag;
    if (rst_n) begin
      rsp_ack = 1'b0;
      rsp_data_valid = 1'b0;
      rsp_data = '0;
      prev_rsp = last_rsp;
      last_rsp = 0;
      if (wrong_chk) begin
        // R6: wrong-kind response must not complete the piece
        chk(!mreq_valid && busy, "R6", "wrong response kind ignored",
            BLK_W'(mreq_valid), BLK_W'(0));
        wrong_chk = 0;
      end
      if (mreq_valid) begin
        if (pending) chk(0, "R5", "piece issued while one outstanding", 1, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R5", "unexpected piece", BLK_W'(mreq_addr), 0);
        end else begin
          p = exp_q.pop_front();
          tag = p.first ? "R3" : "R4";
          chk(mreq_addr == p.addr, tag, "piece addr", BLK_W'(mreq_addr), BLK_W'(p.addr));
          chk(int'(mreq_off) == p.off, tag, "piece offset", BLK_W'(mreq_off), BLK_W'(p.off));
          chk(int'(mreq_len) == p.len, tag, "piece length", BLK_W'(mreq_len), BLK_W'(p.len));
          chk(mreq_write == p.wr, "R6", "piece type", BLK_W'(mreq_write), BLK_W'(p.wr));
          chk(mreq_data == p.data, "R7", "piece data", mreq_data, p.data);
          if (!p.first)
            chk(prev_rsp, "R5", "next piece one cycle after response", BLK_W'(prev_rsp), 1);
          cur_addr = p.addr;
          cur_wr = p.wr;
          pending = 1;
          delay = 1 + (npieces % 3);
          npieces++;
        end
      end else if (pending) begin
        if (delay > 0) begin
          delay--;
        end else if (inject) begin
          if (cur_wr) begin
            rsp_data_valid = 1'b1;
            rsp_data = {BLK{8'hA5}};
          end else begin
            rsp_ack = 1'b1;
          end
          inject = 0;
          wrong_chk = 1;
          delay = 1;
        end else begin
          if (cur_wr) rsp_ack = 1'b1;
          else begin
            rsp_data_valid = 1'b1;
            rsp_data = mem_blk(cur_addr);
          end
          pending = 0;
          last_rsp = 1;
        end
      end
    end
  end

  // driver: builds expected pieces, runs one transfer, checks the outcome
  task automatic run_xfer(input bit wr, input logic [31:0] addr, input int len,
                          input int seed, input bit wrong);
    int done;
    piece_t p;
    if (wr && len > 0) begin
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        buf_we = 1'b1; buf_widx = 8'(k); buf_wdata = host_byte(k, seed);
      end
      @(negedge clk);
      buf_we = 1'b0;
    end
    done = 0;
    while (done < len) begin
      p.first = (done == 0);
      p.off   = p.first ? int'(addr % BLK) : 0;
      p.len   = p.first ? ((len < BLK - p.off) ? len : BLK - p.off)
                        : ((len - done < BLK) ? len - done : BLK);
      p.addr  = addr + 32'(done);
      p.wr    = wr;
      p.data  = '0;
      if (wr) for (int j = 0; j < p.len; j++) p.data[j*8 +: 8] = host_byte(done + j, seed);
      exp_q.push_back(p);
      done += p.len;
    end
    inject = wrong;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready while idle", BLK_W'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_op = wr ? 2'b10 : 2'b01; cmd_addr = addr; cmd_len = 9'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after accept", BLK_W'(busy), 1);
    chk(cmd_ready == 1'b0, "R1", "not ready while busy", BLK_W'(cmd_ready), 0);
    if (len == 0) begin
      chk(done_valid == 1'b1, "R10", "zero-length done next cycle", BLK_W'(done_valid), 1);
      chk(mreq_valid == 1'b0, "R10", "zero-length issues nothing", BLK_W'(mreq_valid), 0);
    end
    if (wr && len > 0) begin
      buf_we = 1'b1; buf_widx = 8'd0; buf_wdata = 8'hEE;   // R12: must be ignored
    end
    while (!done_valid) begin
      @(negedge clk);
      buf_we = 1'b0;
    end
    chk(done_id == exp_id, "R11", "done tag", BLK_W'(done_id), BLK_W'(exp_id));
    chk(exp_q.size() == 0, "R9", "all pieces issued before done", BLK_W'(exp_q.size()), 0);
    @(negedge clk);
    chk(!busy && cmd_ready && !done_valid, "R9", "idle after done", BLK_W'(busy), 0);
    if (!wr) begin
      for (int k = 0; k < len; k++) begin
        buf_ridx = 8'(k);
        #1;
        chk(buf_rdata == mem_byte(addr + 32'(k)), "R8", "load buffer byte",
            BLK_W'(buf_rdata), BLK_W'(mem_byte(addr + 32'(k))));
      end
    end else if (len > 0) begin
      buf_ridx = 8'd0;
      #1;
      chk(buf_rdata == host_byte(0, seed), "R12", "host write ignored while busy",
          BLK_W'(buf_rdata), BLK_W'(host_byte(0, seed)));
    end
    exp_id = exp_id + 4'd1;
  endtask

  task automatic try_illegal(input logic [1:0] op, input int len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = 32'h77; cmd_len = 9'(len);
    #1;
    chk(cmd_illegal == 1'b1, "R2", "refused command flagged", BLK_W'(cmd_illegal), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy && !mreq_valid, "R2", "refused command starts nothing", BLK_W'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R13", "reset ready", BLK_W'(cmd_ready), 1);
    chk(busy == 1'b0, "R13", "reset busy", BLK_W'(busy), 0);
    chk(!mreq_valid && !done_valid, "R13", "reset strobes", BLK_W'(mreq_valid), 0);

    run_xfer(1'b0, 32'h0000_1005, 40, 0, 1'b1);   // unaligned load, 3 pieces, wrong ack
    run_xfer(1'b1, 32'h0000_2000, 32, 9, 1'b1);   // aligned store, wrong data response
    run_xfer(1'b1, 32'h0000_300E, 3, 17, 1'b0);   // store straddling a boundary
    run_xfer(1'b0, 32'h0000_4003, 5, 0, 1'b0);    // load inside one block
    try_illegal(2'b00, 4);
    try_illegal(2'b11, 4);
    try_illegal(2'b01, BUFB + 1);
    run_xfer(1'b0, 32'h0000_50F1, BUFB, 0, 1'b0); // full-buffer load
    for (int t = 0; t < 14; t++) run_xfer(1'b0, 32'h0000_6000, 0, 0, 1'b0); // tag wrap

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule